// File: doc/BRIEF.md
# Debug Entry and Wakeup Controller

This block decides when a small processor core is taken into debug mode and when it may leave again. A debug request can come from a request bit in a control register, from an external request pin, or from a software breakpoint: an all-zero opcode seen in the instruction stream while two separate enables are set. While a request is being served, the block keeps a wakeup request asserted toward the clock generator, so the core clock stays on for the whole debug session.

The block records the core's low-power state (run, wait, halt or stop). If a request arrives while the core sleeps with its clock off, entry is held back until the clock-on indication, passed through a synchronizer, shows that the clock is running again. During debug mode the low-power status outputs read as inactive. When the session ends they show the recorded state again. Leaving debug mode also requires that the pipeline status scan register was updated at least once in that session. A second synchronizer carries the clock-on indication into the test-clock domain, where it serves as a status bit for instruction-register capture.

Top module: `dbg_wake_ctrl`

## Requirements
- R1: `wakeup` is high in every cycle in which `ctrl_dbg_req` or `ext_dbg_req` is high.
- R2: After a register or pin request, `wakeup` stays high after the request is removed. It falls on the clock edge at which `session_active` is first sampled low after having been high.
- R3: In the run state, a register or pin request sampled at a clock edge makes `dbg_mode` high from that edge on.
- R4: In the wait, halt or stop state with the synchronized `clk_on` low, a request does not raise `dbg_mode`. Entry takes place on the third clock edge after `clk_on` rises (two synchronizer stages, then the state register).
- R5: While `dbg_mode` is high, `st_waiting`, `st_halted` and `st_stopped` are all low. After exit they again show the state recorded before entry.
- R6: Debug mode is left only when both conditions hold in the current session: `session_active` has fallen, and a `scan_update` pulse has been seen. If either is missing, `dbg_mode` stays high.
- R7: The record of a `scan_update` is cleared on every entry, so each session needs its own update before exit.
- R8: `clk_on_tck` follows `clk_on` through two `tck` flops and is 0 after reset.
- R9: An instruction of all zero bits with `instr_valid` high, while `dbg_mode_en` and `ext_dbg_en` are both 1, does not enter debug by itself. Entry happens at the edge where the next `instr_valid` instruction is loaded.
- R10: An all-zero instruction while either enable is 0 has no effect: later instructions leave `dbg_mode` low.
- R11: `lp_cmd` (0 run, 1 wait, 2 halt, 3 stop) is taken when `lp_cmd_valid` is high and the block is idle. It is ignored while in debug.
- R12: After a synchronous active-low reset, `dbg_mode`, `wakeup` and all status outputs are 0, and the state is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset (both domains) |
| tck | input | 1 | Test clock |
| ctrl_dbg_req | input | 1 | Debug request bit from control register |
| ext_dbg_req | input | 1 | External debug request pin |
| dbg_mode_en | input | 1 | Debug-mode enable control bit |
| ext_dbg_en | input | 1 | External-debug-mode enable bit |
| session_active | input | 1 | High while a debug session is open |
| clk_on | input | 1 | Asynchronous core-clock-running indication |
| scan_update | input | 1 | Pulse: pipeline status register updated |
| lp_cmd_valid | input | 1 | Low-power state update strobe |
| lp_cmd | input | 2 | New low-power state (0 run, 1 wait, 2 halt, 3 stop) |
| instr_valid | input | 1 | Instruction loaded into instruction register |
| instr | input | IW | Loaded instruction opcode |
| wakeup | output | 1 | Core clock request to clock generator |
| dbg_mode | output | 1 | Debug-entry request to the core |
| st_waiting | output | 1 | Core is in wait state |
| st_halted | output | 1 | Core is in halt state |
| st_stopped | output | 1 | Core is in stop state |
| clk_on_tck | output | 1 | Clock-on status in the test-clock domain |

## Verification
The assertions check these rules on every cycle: status outputs are negated during debug, the held wakeup persists until the session falls, a request against a sleeping core with no clock goes to the clock-wait state, debug mode holds while no update has been seen, and the recorded low-power state is frozen outside idle. Other behaviour needs the bench's scenarios. That covers the exact entry delay after the clock returns, restoring each of the four low-power states after a session, the per-session clearing of the update record, the delayed breakpoint entry, and the three enable combinations that must ignore an all-zero opcode.

// File: rtl/dbg_wake_pkg.sv
// Shared types for the debug entry and wakeup controller.
// Assumes a two-bit low-power state encoding that the core also uses.
package dbg_wake_pkg;
    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_WAIT = 2'd1,
        LP_HALT = 2'd2,
        LP_STOP = 2'd3
    } lp_state_t;

    typedef enum logic [1:0] {
        DS_IDLE    = 2'd0,
        DS_WAITCLK = 2'd1,
        DS_DEBUG   = 2'd2
    } dbg_state_t;
endpackage

// File: rtl/dbg_sync.sv
// Multi-flop synchronizer for one asynchronous level signal.
// Assumes STAGES >= 2 and a reset long enough to cover a few dst_clk edges.
module dbg_sync #(
    parameter int STAGES = 2
) (
    input  logic dst_clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain, cleared by synchronous reset.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_bkpt_detect.sv
// Software breakpoint detector: an all-zero opcode arms a pending flag when
// both enables are set; the next loaded instruction fires the request.
// Assumes 'armed' is high only while the controller is idle.
module dbg_bkpt_detect #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    input  logic          dbg_mode_en,
    input  logic          ext_dbg_en,
    input  logic          armed,
    output logic          fire
);
    logic pend_q;
    logic zero_op;
    logic hit;

    assign zero_op = instr_valid && (instr == '0);
    assign hit     = zero_op && dbg_mode_en && ext_dbg_en && armed;
    assign fire    = pend_q && instr_valid && armed;

    // Track a seen breakpoint until the following instruction loads.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (!armed) pend_q <= 1'b0;
        else if (fire)   pend_q <= 1'b0;
        else if (hit)    pend_q <= 1'b1;
    end

    // R10
    ignored_zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_op && !(dbg_mode_en && ext_dbg_en) && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dbg_entry_fsm.sv
// Debug entry/exit state machine plus recorded low-power state.
// Assumes session_fall is a one-cycle pulse and clk_on_s is synchronized.
module dbg_entry_fsm
    import dbg_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ent_req,
    input  logic      bkpt_fire,
    input  logic      clk_on_s,
    input  logic      session_fall,
    input  logic      scan_update,
    input  logic      lp_cmd_valid,
    input  logic [1:0] lp_cmd,
    output logic      in_debug,
    output logic      idle,
    output lp_state_t lp_q
);
    dbg_state_t state_q;
    logic       upd_seen_q;
    logic       sess_done_q;
    logic       any_req;

    assign any_req  = ent_req || bkpt_fire;
    assign in_debug = (state_q == DS_DEBUG);
    assign idle     = (state_q == DS_IDLE);

    // Sequence entry, clock wait, session tracking and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= DS_IDLE;
            lp_q        <= LP_RUN;
            upd_seen_q  <= 1'b0;
            sess_done_q <= 1'b0;
        end else begin
            case (state_q)
                DS_IDLE: begin
                    if (any_req) begin
                        upd_seen_q  <= 1'b0;
                        sess_done_q <= 1'b0;
                        if (lp_q == LP_RUN || clk_on_s) state_q <= DS_DEBUG;
                        else                            state_q <= DS_WAITCLK;
                    end else if (lp_cmd_valid) begin
                        lp_q <= lp_state_t'(lp_cmd);
                    end
                end
                DS_WAITCLK: begin
                    if (clk_on_s) begin
                        state_q     <= DS_DEBUG;
                        upd_seen_q  <= 1'b0;
                        sess_done_q <= 1'b0;
                    end
                end
                DS_DEBUG: begin
                    if (scan_update)  upd_seen_q  <= 1'b1;
                    if (session_fall) sess_done_q <= 1'b1;
                    if (upd_seen_q && sess_done_q) state_q <= DS_IDLE;
                end
                default: state_q <= DS_IDLE;
            endcase
        end
    end

    // R4
    sleep_wait_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && any_req && lp_q != LP_RUN && !clk_on_s) |=> (state_q == DS_WAITCLK));

    // R6
    hold_until_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_debug && !upd_seen_q) |=> in_debug);

    // R11
    lp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> (lp_q == $past(lp_q)));
endmodule

// File: rtl/dbg_wake_ctrl.sv
// Top of the debug entry and wakeup controller: request merge, wakeup latch,
// session edge detect, synchronizers, breakpoint detector and entry FSM.
// Assumes clk is always on; core clock status arrives on clk_on asynchronously.
module dbg_wake_ctrl
    import dbg_wake_pkg::*;
#(
    parameter int IW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tck,
    input  logic          ctrl_dbg_req,
    input  logic          ext_dbg_req,
    input  logic          dbg_mode_en,
    input  logic          ext_dbg_en,
    input  logic          session_active,
    input  logic          clk_on,
    input  logic          scan_update,
    input  logic          lp_cmd_valid,
    input  logic [1:0]    lp_cmd,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr,
    output logic          wakeup,
    output logic          dbg_mode,
    output logic          st_waiting,
    output logic          st_halted,
    output logic          st_stopped,
    output logic          clk_on_tck
);
    logic      raw_req;
    logic      wake_q;
    logic      sess_q;
    logic      session_fall;
    logic      clk_on_s;
    logic      bkpt_fire;
    logic      idle;
    lp_state_t lp_q;

    assign raw_req      = ctrl_dbg_req || ext_dbg_req;
    assign session_fall = sess_q && !session_active;

    // Remember the previous session level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sess_q <= 1'b0;
        else        sess_q <= session_active;
    end

    // Hold the wakeup from a request until the session ends.
    always_ff @(posedge clk) begin
        if (!rst_n)            wake_q <= 1'b0;
        else if (raw_req)      wake_q <= 1'b1;
        else if (session_fall) wake_q <= 1'b0;
    end

    assign wakeup = wake_q || raw_req;

    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_core (
        .dst_clk (clk),
        .rst_n   (rst_n),
        .async_in(clk_on),
        .sync_out(clk_on_s)
    );

    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync_tck (
        .dst_clk (tck),
        .rst_n   (rst_n),
        .async_in(clk_on),
        .sync_out(clk_on_tck)
    );

    dbg_bkpt_detect #(.IW(IW)) u_bkpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .instr      (instr),
        .dbg_mode_en(dbg_mode_en),
        .ext_dbg_en (ext_dbg_en),
        .armed      (idle),
        .fire       (bkpt_fire)
    );

    dbg_entry_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ent_req     (raw_req),
        .bkpt_fire   (bkpt_fire),
        .clk_on_s    (clk_on_s),
        .session_fall(session_fall),
        .scan_update (scan_update),
        .lp_cmd_valid(lp_cmd_valid),
        .lp_cmd      (lp_cmd),
        .in_debug    (dbg_mode),
        .idle        (idle),
        .lp_q        (lp_q)
    );

    assign st_waiting = !dbg_mode && (lp_q == LP_WAIT);
    assign st_halted  = !dbg_mode && (lp_q == LP_HALT);
    assign st_stopped = !dbg_mode && (lp_q == LP_STOP);

    // R1
    wake_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_req |-> wakeup);

    // R2
    wake_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_q && !session_fall) |=> wakeup);

    // R5
    status_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !(st_waiting || st_halted || st_stopped));
endmodule

// File: tb/tb_dbg_wake_ctrl.sv
module tb_dbg_wake_ctrl;
    localparam int IW = 32;

    logic clk = 1'b0, tck = 1'b0, rst_n = 1'b0;
    logic ctrl_dbg_req = 0, ext_dbg_req = 0, dbg_mode_en = 0, ext_dbg_en = 0;
    logic session_active = 0, clk_on = 0, scan_update = 0, lp_cmd_valid = 0;
    logic [1:0] lp_cmd = 0;
    logic instr_valid = 0;
    logic [IW-1:0] instr = '0;
    logic wakeup, dbg_mode, st_waiting, st_halted, st_stopped, clk_on_tck;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always #7 tck = ~tck;

    dbg_wake_ctrl #(.IW(IW)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int st_code();
        return {29'd0, st_stopped, st_halted, st_waiting};
    endfunction

    function automatic int exp_st(input int lp);
        return (lp == 0) ? 0 : (1 << (lp - 1));
    endfunction

    task automatic set_lp(input int v);
        lp_cmd_valid = 1; lp_cmd = 2'(v);
        step(1);
        lp_cmd_valid = 0;
    endtask

    task automatic end_session(input bit upd);
        session_active = 1;
        step(2);
        if (upd) begin scan_update = 1; step(1); scan_update = 0; end
        step(1);
        session_active = 0;
        step(4);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(6);
        // R12 reset state
        check(dbg_mode == 0, "R12", dbg_mode, 0);
        check(wakeup == 0, "R12", wakeup, 0);
        check(st_code() == 0, "R12", st_code(), 0);
        check(clk_on_tck == 0, "R8", clk_on_tck, 0);
        rst_n = 1;
        step(2);
        // R8 tck-domain status follows clk_on
        clk_on = 1;
        #45;
        check(clk_on_tck == 1, "R8", clk_on_tck, 1);
        clk_on = 0;
        #45;
        check(clk_on_tck == 0, "R8", clk_on_tck, 0);
        clk_on = 1;
        step(4);

        // R1 R2 R3 R5 R11 sweep: every low-power state x both request sources
        for (int lp = 0; lp < 4; lp++) begin
            for (int src = 0; src < 2; src++) begin
                set_lp(lp);
                check(st_code() == exp_st(lp), "R11", st_code(), exp_st(lp));
                if (src == 0) ctrl_dbg_req = 1; else ext_dbg_req = 1;
                #1;
                check(wakeup == 1, "R1", wakeup, 1);
                step(1);
                check(dbg_mode == 1, "R3", dbg_mode, 1);
                check(st_code() == 0, "R5", st_code(), 0);
                ctrl_dbg_req = 0; ext_dbg_req = 0;
                lp_cmd_valid = 1; lp_cmd = 2'(3 - lp);
                step(1);
                lp_cmd_valid = 0;
                step(1);
                check(wakeup == 1, "R2", wakeup, 1);
                end_session(1);
                check(dbg_mode == 0, "R6", dbg_mode, 0);
                check(wakeup == 0, "R2", wakeup, 0);
                check(st_code() == exp_st(lp), "R5", st_code(), exp_st(lp));
            end
        end

        // R4: sleeping core with clock off waits for synchronized clock-on
        for (int lp = 1; lp < 4; lp++) begin
            set_lp(lp);
            clk_on = 0;
            step(4);
            ctrl_dbg_req = 1;
            step(6);
            check(dbg_mode == 0, "R4", dbg_mode, 0);
            check(wakeup == 1, "R1", wakeup, 1);
            clk_on = 1;
            step(2);
            check(dbg_mode == 0, "R4", dbg_mode, 0);
            step(1);
            check(dbg_mode == 1, "R4", dbg_mode, 1);
            ctrl_dbg_req = 0;
            end_session(1);
            check(st_code() == exp_st(lp), "R5", st_code(), exp_st(lp));
        end
        set_lp(0);

        // R6: no update during session keeps debug mode
        ext_dbg_req = 1; step(1); ext_dbg_req = 0;
        end_session(0);
        check(dbg_mode == 1, "R6", dbg_mode, 1);
        check(wakeup == 0, "R2", wakeup, 0);
        scan_update = 1; step(1); scan_update = 0;
        step(1);
        check(dbg_mode == 0, "R6", dbg_mode, 0);

        // R7: update record does not carry into the next session
        ctrl_dbg_req = 1; step(1); ctrl_dbg_req = 0;
        end_session(1);
        check(dbg_mode == 0, "R7", dbg_mode, 0);
        ctrl_dbg_req = 1; step(1); ctrl_dbg_req = 0;
        end_session(0);
        check(dbg_mode == 1, "R7", dbg_mode, 1);
        scan_update = 1; step(1); scan_update = 0;
        step(2);
        check(dbg_mode == 0, "R7", dbg_mode, 0);

        // R10: all-zero opcode with an enable missing is ignored
        for (int en = 0; en < 3; en++) begin
            dbg_mode_en = en[0]; ext_dbg_en = en[1];
            instr_valid = 1; instr = '0; step(1);
            instr = 32'h13; step(3);
            instr_valid = 0; step(1);
            check(dbg_mode == 0, "R10", dbg_mode, 0);
        end

        // R9: breakpoint enters after the following instruction loads
        dbg_mode_en = 1; ext_dbg_en = 1;
        instr_valid = 1; instr = '0; step(1);
        instr_valid = 0; step(3);
        check(dbg_mode == 0, "R9", dbg_mode, 0);
        instr_valid = 1; instr = 32'h13; step(1);
        instr_valid = 0;
        check(dbg_mode == 1, "R9", dbg_mode, 1);
        end_session(1);
        check(dbg_mode == 0, "R9", dbg_mode, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule